// File: doc/BRIEF.md
# Burst Access Command Sequencer

This block sits behind the command decoder of a DRAM device and executes the read/write accesses that are addressed to it. Each access arrives as a single strobe carrying a 6-bit command code together with a bank, a row and a starting column. The code bits select whether a row must be opened first, whether the burst is four or eight words long, the transfer direction, whether the row is closed afterwards, and which of two data clock pairs carries the data. The sequencer expands that one code into timed activate, beat and precharge strobes for an array of eight banks.

A per-bank table holds an open flag and the open row number. An access that relies on an already open row is checked against this table and dropped with a one-cycle protocol-error pulse when the bank is closed or holds another row. Codes with the top bit set are maintenance operations: they are handed on through a separate one-cycle port and never start a sequence. While a sequence runs, a busy flag is high and further command strobes are ignored.

Top module: `bseq_top`

## Requirements
- R1: After reset, busy and all strobes (activate, read beat, write beat, precharge, maintenance, protocol error) are low and every bank is closed.
- R2: An accepted command with code bit 5 = 1 produces a one-cycle maint_valid pulse in the cycle after acceptance, with maint_code equal to the code; no sequence starts and busy stays low.
- R3: An access with code bit 4 = 1 pulses act_stb for one cycle in the cycle after acceptance with act_bank/act_row equal to the command; the first beat follows T_RCD cycles after that activate cycle, and the bank is recorded open on that row.
- R4: An access with code bit 4 = 0 to a bank that is open on the same row issues no activate; its first beat appears in the cycle right after acceptance.
- R5: An access with code bit 4 = 0 to a closed bank, or to an open bank holding a different row, produces a one-cycle prot_err pulse in the cycle after acceptance and no other strobe; busy stays low and the bank table is unchanged.
- R6: Code bit 3 selects a burst of 8 beats (1) or 4 beats (0) in consecutive cycles; beat_idx counts 0 up to length-1, beat_bank is the command bank and beat_col is the start column plus beat_idx modulo 2^COL_W. Every write beat covers a whole word (no partial writes).
- R7: Code bit 2 = 1 makes every beat a write (wr_beat), 0 makes every beat a read (rd_beat); the two are never high together.
- R8: Code bit 1 = 1 pulses pre_stb with pre_bank equal to the command bank T_WRP cycles after the last beat and leaves the bank closed; bit 1 = 0 leaves the row open.
- R9: During every beat of a burst, dclk_sel equals code bit 0.
- R10: busy is high from the cycle after acceptance through the last strobe of the sequence and low in the next cycle; command strobes while busy is high are ignored.
- R11: Each bank keeps its own open state and row, so rows may be open in several banks at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when busy is low |
| cmd_code | input | 6 | Command code |
| cmd_bank | input | 3 | Target bank |
| cmd_row | input | ROW_W | Row address |
| cmd_col | input | COL_W | Starting column |
| busy | output | 1 | Sequence in progress; commands ignored |
| maint_valid | output | 1 | One-cycle maintenance hand-off strobe |
| maint_code | output | 6 | Code handed to the maintenance port |
| prot_err | output | 1 | One-cycle pulse: open-row access refused |
| act_stb | output | 1 | Row activate strobe |
| act_bank | output | 3 | Bank being activated |
| act_row | output | ROW_W | Row being activated |
| rd_beat | output | 1 | Read beat strobe |
| wr_beat | output | 1 | Write beat strobe |
| beat_idx | output | 3 | Burst word counter |
| beat_bank | output | 3 | Bank of the current beat |
| beat_col | output | COL_W | Column of the current beat |
| dclk_sel | output | 1 | Data clock pair select for the transfer |
| pre_stb | output | 1 | Precharge strobe |
| pre_bank | output | 3 | Bank being precharged |

## Verification
The assertions assume that the command inputs are stable around the clock edge and that a command is only meaningful when busy is low; they make no assumption about what the code, bank or row hold. The stimulus changes inputs on the falling edge, normally waits for busy to drop before the next command, and deliberately drives strobes during busy to show they are ignored. Row values are drawn from a small set so that open-row hits, row mismatches and closed-bank misses all occur.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  localparam int CODE_W = 6;

  typedef struct packed {
    logic maint;       // bit 5: maintenance operation
    logic open_row;    // bit 4: activate before access
    logic long_burst;  // bit 3: 8 beats instead of 4
    logic write;       // bit 2: write direction
    logic close;       // bit 1: precharge after burst
    logic dsel;        // bit 0: data clock pair
  } cmd_fields_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_BURST,
    ST_GAP,
    ST_CLOSE
  } seq_state_t;

  function automatic cmd_fields_t split_code(input logic [CODE_W-1:0] c);
    cmd_fields_t f;
    f.maint      = c[5];
    f.open_row   = c[4];
    f.long_burst = c[3];
    f.write      = c[2];
    f.close      = c[1];
    f.dsel       = c[0];
    return f;
  endfunction

endpackage

// File: rtl/bseq_decode.sv
module bseq_decode
  import bseq_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output cmd_fields_t       fields
);

  always_comb begin
    fields = split_code(code);
  end

endmodule

// File: rtl/bseq_rowtab.sv
module bseq_rowtab #(
  parameter int NBANK  = 8,
  parameter int ROW_W  = 12,
  parameter int BANK_W = $clog2(NBANK)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic              set_open,
  input  logic              set_closed,
  input  logic [BANK_W-1:0] bank,
  input  logic [ROW_W-1:0]  row,
  output logic              hit
);

  logic [NBANK-1:0] open_q;
  logic [ROW_W-1:0] rows [NBANK];

  // one open flag per bank, each with its own enable
  for (genvar b = 0; b < NBANK; b++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        open_q[b] <= 1'b0;
      end else if (upd && bank == BANK_W'(b)) begin
        if (set_closed)    open_q[b] <= 1'b0;
        else if (set_open) open_q[b] <= 1'b1;
      end
    end
  end

  // row storage: single write port, no reset
  always_ff @(posedge clk) begin
    if (upd && set_open && !set_closed) rows[bank] <= row;
  end

  assign hit = open_q[bank] && (rows[bank] == row);

endmodule

// File: rtl/bseq_engine.sv
module bseq_engine
  import bseq_pkg::*;
#(
  parameter int NBANK    = 8,
  parameter int ROW_W    = 12,
  parameter int COL_W    = 7,
  parameter int T_RCD    = 3,
  parameter int T_WRP    = 2,
  parameter int BL_SHORT = 4,
  parameter int BL_LONG  = 8,
  parameter int BANK_W   = $clog2(NBANK),
  parameter int IDX_W    = $clog2(BL_LONG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [CODE_W-1:0] cmd_code,
  input  cmd_fields_t       f,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [ROW_W-1:0]  cmd_row,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic              hit,
  output logic              accept,
  output logic              busy,
  output logic              maint_valid,
  output logic [CODE_W-1:0] maint_code,
  output logic              prot_err,
  output logic              act_stb,
  output logic [BANK_W-1:0] act_bank,
  output logic [ROW_W-1:0]  act_row,
  output logic              rd_beat,
  output logic              wr_beat,
  output logic [IDX_W-1:0]  beat_idx,
  output logic [BANK_W-1:0] beat_bank,
  output logic [COL_W-1:0]  beat_col,
  output logic              dclk_sel,
  output logic              pre_stb,
  output logic [BANK_W-1:0] pre_bank
);

  localparam int MAXW      = (T_RCD > T_WRP) ? T_RCD : T_WRP;
  localparam int CNT_W     = $clog2(MAXW + 1);
  localparam int OPEN_LOAD = (T_RCD > 1) ? T_RCD - 1 : 0;
  localparam int GAP_LOAD  = (T_WRP > 1) ? T_WRP - 2 : 0;

  seq_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [BANK_W-1:0] l_bank;
  logic [COL_W-1:0]  l_col;
  logic [IDX_W-1:0]  l_last;
  logic              l_write, l_close, l_dsel;
  logic              take;
  logic [IDX_W-1:0]  last_of_cmd;

  assign take        = cmd_valid && (state == ST_IDLE);
  assign accept      = take && !f.maint && (f.open_row || hit);
  assign last_of_cmd = f.long_burst ? IDX_W'(BL_LONG - 1) : IDX_W'(BL_SHORT - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      busy        <= 1'b0;
      maint_valid <= 1'b0;
      maint_code  <= '0;
      prot_err    <= 1'b0;
      act_stb     <= 1'b0;
      act_bank    <= '0;
      act_row     <= '0;
      rd_beat     <= 1'b0;
      wr_beat     <= 1'b0;
      beat_idx    <= '0;
      beat_bank   <= '0;
      beat_col    <= '0;
      dclk_sel    <= 1'b0;
      pre_stb     <= 1'b0;
      pre_bank    <= '0;
      l_bank      <= '0;
      l_col       <= '0;
      l_last      <= '0;
      l_write     <= 1'b0;
      l_close     <= 1'b0;
      l_dsel      <= 1'b0;
    end else begin
      maint_valid <= 1'b0;
      prot_err    <= 1'b0;
      act_stb     <= 1'b0;
      pre_stb     <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (take) begin
            if (f.maint) begin
              maint_valid <= 1'b1;
              maint_code  <= cmd_code;
            end else if (!accept) begin
              prot_err <= 1'b1;
            end else begin
              busy    <= 1'b1;
              l_bank  <= cmd_bank;
              l_col   <= cmd_col;
              l_last  <= last_of_cmd;
              l_write <= f.write;
              l_close <= f.close;
              l_dsel  <= f.dsel;
              if (f.open_row) begin
                act_stb  <= 1'b1;
                act_bank <= cmd_bank;
                act_row  <= cmd_row;
                cnt      <= CNT_W'(OPEN_LOAD);
                state    <= ST_OPEN;
              end else begin
                rd_beat   <= !f.write;
                wr_beat   <= f.write;
                beat_idx  <= '0;
                beat_bank <= cmd_bank;
                beat_col  <= cmd_col;
                dclk_sel  <= f.dsel;
                state     <= ST_BURST;
              end
            end
          end
        end
        ST_OPEN: begin
          if (cnt == '0) begin
            rd_beat   <= !l_write;
            wr_beat   <= l_write;
            beat_idx  <= '0;
            beat_bank <= l_bank;
            beat_col  <= l_col;
            dclk_sel  <= l_dsel;
            state     <= ST_BURST;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_BURST: begin
          if (beat_idx == l_last) begin
            rd_beat <= 1'b0;
            wr_beat <= 1'b0;
            if (!l_close) begin
              busy  <= 1'b0;
              state <= ST_IDLE;
            end else if (T_WRP <= 1) begin
              pre_stb  <= 1'b1;
              pre_bank <= l_bank;
              state    <= ST_CLOSE;
            end else begin
              cnt   <= CNT_W'(GAP_LOAD);
              state <= ST_GAP;
            end
          end else begin
            beat_idx <= beat_idx + 1'b1;
            beat_col <= beat_col + 1'b1;
          end
        end
        ST_GAP: begin
          if (cnt == '0) begin
            pre_stb  <= 1'b1;
            pre_bank <= l_bank;
            state    <= ST_CLOSE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_CLOSE: begin
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bseq_top.sv
module bseq_top
  import bseq_pkg::*;
#(
  parameter int NBANK    = 8,
  parameter int ROW_W    = 12,
  parameter int COL_W    = 7,
  parameter int T_RCD    = 3,
  parameter int T_WRP    = 2,
  parameter int BL_SHORT = 4,
  parameter int BL_LONG  = 8,
  localparam int BANK_W  = $clog2(NBANK),
  localparam int IDX_W   = $clog2(BL_LONG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [5:0]        cmd_code,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [ROW_W-1:0]  cmd_row,
  input  logic [COL_W-1:0]  cmd_col,
  output logic              busy,
  output logic              maint_valid,
  output logic [5:0]        maint_code,
  output logic              prot_err,
  output logic              act_stb,
  output logic [BANK_W-1:0] act_bank,
  output logic [ROW_W-1:0]  act_row,
  output logic              rd_beat,
  output logic              wr_beat,
  output logic [IDX_W-1:0]  beat_idx,
  output logic [BANK_W-1:0] beat_bank,
  output logic [COL_W-1:0]  beat_col,
  output logic              dclk_sel,
  output logic              pre_stb,
  output logic [BANK_W-1:0] pre_bank
);

  cmd_fields_t fields;
  logic        hit;
  logic        accept;

  bseq_decode u_dec (
    .code   (cmd_code),
    .fields (fields)
  );

  bseq_rowtab #(
    .NBANK (NBANK),
    .ROW_W (ROW_W)
  ) u_tab (
    .clk        (clk),
    .rst        (rst),
    .upd        (accept),
    .set_open   (fields.open_row),
    .set_closed (fields.close),
    .bank       (cmd_bank),
    .row        (cmd_row),
    .hit        (hit)
  );

  bseq_engine #(
    .NBANK    (NBANK),
    .ROW_W    (ROW_W),
    .COL_W    (COL_W),
    .T_RCD    (T_RCD),
    .T_WRP    (T_WRP),
    .BL_SHORT (BL_SHORT),
    .BL_LONG  (BL_LONG)
  ) u_eng (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .f           (fields),
    .cmd_bank    (cmd_bank),
    .cmd_row     (cmd_row),
    .cmd_col     (cmd_col),
    .hit         (hit),
    .accept      (accept),
    .busy        (busy),
    .maint_valid (maint_valid),
    .maint_code  (maint_code),
    .prot_err    (prot_err),
    .act_stb     (act_stb),
    .act_bank    (act_bank),
    .act_row     (act_row),
    .rd_beat     (rd_beat),
    .wr_beat     (wr_beat),
    .beat_idx    (beat_idx),
    .beat_bank   (beat_bank),
    .beat_col    (beat_col),
    .dclk_sel    (dclk_sel),
    .pre_stb     (pre_stb),
    .pre_bank    (pre_bank)
  );

endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic             maint_valid,
  input logic             prot_err,
  input logic             act_stb,
  input logic             rd_beat,
  input logic             wr_beat,
  input logic [IDX_W-1:0] beat_idx,
  input logic             dclk_sel,
  input logic             pre_stb
);

  // R7
  dir_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(rd_beat && wr_beat));

  // R3
  act_single_chk: assert property (@(posedge clk) disable iff (rst)
    act_stb |=> !act_stb);

  // R10
  strobes_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (act_stb || rd_beat || wr_beat || pre_stb) |-> busy);

  // R5
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    prot_err |-> (!busy && !act_stb && !rd_beat && !wr_beat && !pre_stb));

  // R2
  maint_idle_chk: assert property (@(posedge clk) disable iff (rst)
    maint_valid |-> (!busy && !prot_err && !act_stb));

  // R6
  beat_step_chk: assert property (@(posedge clk) disable iff (rst)
    ((rd_beat || wr_beat) && beat_idx != '0) |->
      ($past(rd_beat || wr_beat) && beat_idx == $past(beat_idx) + 1'b1));

  // R9
  dsel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((rd_beat || wr_beat) && beat_idx != '0) |-> $stable(dclk_sel));

  // R8
  pre_single_chk: assert property (@(posedge clk) disable iff (rst)
    pre_stb |=> (!pre_stb && !busy));

endmodule

bind bseq_top bseq_chk #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .busy        (busy),
  .maint_valid (maint_valid),
  .prot_err    (prot_err),
  .act_stb     (act_stb),
  .rd_beat     (rd_beat),
  .wr_beat     (wr_beat),
  .beat_idx    (beat_idx),
  .dclk_sel    (dclk_sel),
  .pre_stb     (pre_stb)
);

// File: tb/bseq_top_test.sv
`timescale 1ns/1ps
module bseq_top_test;

  localparam int NBANK = 8, ROW_W = 12, COL_W = 7;
  localparam int T_RCD = 3, T_WRP = 2;

  logic clk = 0, rst = 1;
  logic cmd_valid = 0;
  logic [5:0] cmd_code = 0;
  logic [2:0] cmd_bank = 0;
  logic [ROW_W-1:0] cmd_row = 0;
  logic [COL_W-1:0] cmd_col = 0;
  logic busy, maint_valid, prot_err, act_stb, rd_beat, wr_beat, dclk_sel, pre_stb;
  logic [5:0] maint_code;
  logic [2:0] act_bank, beat_idx, beat_bank, pre_bank;
  logic [ROW_W-1:0] act_row;
  logic [COL_W-1:0] beat_col;

  always #10 clk = ~clk;

  bseq_top uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col),
    .busy(busy), .maint_valid(maint_valid), .maint_code(maint_code),
    .prot_err(prot_err), .act_stb(act_stb), .act_bank(act_bank),
    .act_row(act_row), .rd_beat(rd_beat), .wr_beat(wr_beat),
    .beat_idx(beat_idx), .beat_bank(beat_bank), .beat_col(beat_col),
    .dclk_sel(dclk_sel), .pre_stb(pre_stb), .pre_bank(pre_bank)
  );

  typedef struct {
    bit busy; bit act; bit rd; bit wr; bit pre; bit dsel;
    int bank; int row; int idx; int col;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  bit   m_maint, m_perr, started;
  int   m_code;
  bit   open_m [NBANK];
  int   row_m  [NBANK];
  int   checks = 0, fails = 0;
  bit   done = 0;

  function automatic exp_t idle_e();
    exp_t e;
    e = '{default: 0};
    return e;
  endfunction

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      cur = idle_e();
      m_maint = 0; m_perr = 0;
      for (int b = 0; b < NBANK; b++) begin open_m[b] = 0; row_m[b] = 0; end
      started = 1;
    end else begin
      bit took;
      took = cmd_valid && !cur.busy;
      m_maint = 0; m_perr = 0;
      if (took && cmd_code[5]) begin
        m_maint = 1; m_code = cmd_code;
      end else if (took) begin
        int b, len;
        b = cmd_bank;
        if (!cmd_code[4] && !(open_m[b] && row_m[b] == int'(cmd_row))) begin
          m_perr = 1;
        end else begin
          exp_t e;
          len = cmd_code[3] ? 8 : 4;
          if (cmd_code[4]) begin
            e = idle_e(); e.busy = 1; e.act = 1; e.bank = b; e.row = cmd_row;
            q.push_back(e);
            for (int i = 1; i < T_RCD; i++) begin e = idle_e(); e.busy = 1; q.push_back(e); end
          end
          for (int i = 0; i < len; i++) begin
            e = idle_e(); e.busy = 1; e.rd = !cmd_code[2]; e.wr = cmd_code[2];
            e.idx = i; e.bank = b; e.col = (int'(cmd_col) + i) % (1 << COL_W);
            e.dsel = cmd_code[0];
            q.push_back(e);
          end
          if (cmd_code[1]) begin
            for (int i = 1; i < T_WRP; i++) begin e = idle_e(); e.busy = 1; q.push_back(e); end
            e = idle_e(); e.busy = 1; e.pre = 1; e.bank = b; q.push_back(e);
            open_m[b] = 0;
          end else if (cmd_code[4]) begin
            open_m[b] = 1; row_m[b] = cmd_row;
          end
        end
      end
      cur = (q.size() != 0) ? q.pop_front() : idle_e();
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare on the falling edge of every cycle
  always @(negedge clk) begin
    if (started && !done) begin
      chk(busy == cur.busy, "R10", "busy", busy, cur.busy);
      chk(act_stb == cur.act, "R3", "act_stb", act_stb, cur.act);
      chk(rd_beat == cur.rd, "R7", "rd_beat", rd_beat, cur.rd);
      chk(wr_beat == cur.wr, "R7", "wr_beat", wr_beat, cur.wr);
      chk(pre_stb == cur.pre, "R8", "pre_stb", pre_stb, cur.pre);
      chk(maint_valid == m_maint, "R2", "maint_valid", maint_valid, m_maint);
      chk(prot_err == m_perr, "R5", "prot_err", prot_err, m_perr);
      if (m_maint) chk(int'(maint_code) == m_code, "R2", "maint_code", maint_code, m_code);
      if (cur.act) begin
        chk(int'(act_bank) == cur.bank, "R3", "act_bank", act_bank, cur.bank);
        chk(int'(act_row) == cur.row, "R3", "act_row", act_row, cur.row);
      end
      if (cur.rd || cur.wr) begin
        chk(int'(beat_idx) == cur.idx, "R6", "beat_idx", beat_idx, cur.idx);
        chk(int'(beat_bank) == cur.bank, "R6", "beat_bank", beat_bank, cur.bank);
        chk(int'(beat_col) == cur.col, "R6", "beat_col", beat_col, cur.col);
        chk(dclk_sel == cur.dsel, "R9", "dclk_sel", dclk_sel, cur.dsel);
      end
      if (cur.pre) chk(int'(pre_bank) == cur.bank, "R8", "pre_bank", pre_bank, cur.bank);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic send(input logic [5:0] c, input int b, input int r, input int col);
    @(negedge clk);
    cmd_valid = 1; cmd_code = c; cmd_bank = 3'(b); cmd_row = ROW_W'(r); cmd_col = COL_W'(col);
    @(negedge clk);
    cmd_valid = 0;
    while (cur.busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int x;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1: outputs idle after reset, every bank closed
    @(negedge clk);
    chk(!busy && !act_stb && !rd_beat && !wr_beat && !pre_stb && !prot_err && !maint_valid,
        "R1", "idle after reset", busy, 0);
    send(6'b000000, 2, 0, 0);              // R1/R5: bank 2 closed -> error
    send(6'b100101, 0, 0, 0);              // R2: maintenance hand-off
    send(6'b010000, 1, 'h123, 5);          // R3: activate, short read, keep open
    send(6'b001001, 1, 'h123, 'h7E);       // R4/R6: open-row long read, column wrap, pair 1
    send(6'b000000, 1, 'h124, 0);          // R5: row mismatch
    send(6'b011111, 3, 'h055, 9);          // R8: activate, long write, close, pair 1
    send(6'b000100, 3, 'h055, 0);          // R8: bank 3 now closed -> error
    send(6'b010000, 0, 'h010, 0);          // R11: open bank 0
    send(6'b010101, 7, 'h020, 1);          // R11: open bank 7, write
    send(6'b000000, 0, 'h010, 3);          // R11: bank 0 still open
    send(6'b000110, 7, 'h020, 2);          // R11/R8: write and close bank 7
    send(6'b000110, 0, 'h010, 4);          // R8: close bank 0
    // R10: strobes during busy are ignored
    @(negedge clk);
    cmd_valid = 1; cmd_code = 6'b011010; cmd_bank = 3'd5; cmd_row = 'h0AA; cmd_col = 0;
    @(negedge clk);
    cmd_code = 6'b100011; cmd_bank = 3'd2;
    repeat (6) @(negedge clk);
    cmd_code = 6'b000000; cmd_bank = 3'd4;
    repeat (4) @(negedge clk);
    cmd_valid = 0;
    while (cur.busy) @(negedge clk);
    @(negedge clk);
    // mixed pattern over all code bits, small row set
    x = 7;
    for (int n = 0; n < 60; n++) begin
      x = x * 1103515245 + 12345;
      send({(x[20:17] == 4'hF), x[9:5]}, x[12:10], x[14:13] % 2, x[27:21]);
    end
    finish_run();
  end

endmodule